// File: doc/BRIEF.md
# Per-Pin Interrupt Detect Controller

The controller watches a bank of asynchronous input pins and turns selected conditions on them into interrupt requests. Each pin first passes through a synchroniser. A small per-pin trigger code then chooses which condition on that pin raises its flag: a low level, a high level, a rising edge, a falling edge or either edge. Any other code leaves the pin silent.

Every pin owns one bit in a shared sticky status word. The bits of that word are ORed together to form a single interrupt line. Software reaches the per-pin control words and the status word over a plain single-cycle memory-mapped bus. Reads return data in the same cycle. A status flag is cleared by writing a one to its bit. A flag raised by a level trigger comes back at once for as long as the level is still present.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every control word reads 0, the status word reads 0 and `irq_out` is 0.
- R2: The control word of pin n sits at byte address 4*n (n = 0..31). Its trigger code is stored in bits 19:16 and reads back there, and all other bits read 0. Writes to unmapped or misaligned addresses are ignored, and reads from them return 0.
- R3: Trigger codes: 0x0 off, 0x8 low level, 0x9 rising edge, 0xA falling edge, 0xB either edge, 0xC high level. Every other code behaves as off and never raises a flag.
- R4: In rising-edge mode, a 0-to-1 change on the synchronised pin sets the pin's flag. The flag is readable three clock edges after the pin changes, because there are two synchroniser stages and then the flag register. The flag stays set until software clears it.
- R5: Falling-edge mode flags a 1-to-0 change. Either-edge mode flags both kinds of change.
- R6: Low-level and high-level modes set the flag in every cycle that the active level is present, so a clear issued while the level persists does not stay in effect.
- R7: The status word sits at byte address 0xA0, with bit n belonging to pin n. Writing a 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R8: If a trigger condition and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_out` is 1 exactly when at least one status flag is set.
- R10: Writing 0 to a control word stops further flags from that pin. Flags that are already set are kept.
- R11: Edges are ignored during the first three clock edges after reset release, so a pin held high through reset never produces a spurious rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 32 | Asynchronous input pins |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_out | output | 1 | OR of all status flags |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a fresh trigger. With three register stages between a pin and its flag, an edge must be timed exactly against the bus write. The stimulus does this deterministically by holding a level-triggered pin in its active state, which makes a trigger occur in every cycle, and then issuing the clear. Randomised traffic adds edge/clear collisions on edge-mode pins, and the cycle model in the bench tracks those. The spurious edge after reset is also created on purpose: the pins are held high through reset and a rising-edge code is written in the first cycle after release.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic [3:0] {
    TRIG_OFF      = 4'h0,
    TRIG_LVL_LO   = 4'h8,
    TRIG_RISE     = 4'h9,
    TRIG_FALL     = 4'hA,
    TRIG_ANY_EDGE = 4'hB,
    TRIG_LVL_HI   = 4'hC
  } trig_mode_e;

  localparam int MODE_LSB      = 16;
  localparam int MODE_W        = 4;
  localparam int STATUS_OFFSET = 160;

  // Decide whether a pin's trigger condition holds this cycle.
  function automatic logic trig_hit(input logic [MODE_W-1:0] mode,
                                    input logic cur,
                                    input logic prev,
                                    input logic edges_ok);
    logic hit;
    case (mode)
      TRIG_LVL_LO:   hit = ~cur;
      TRIG_LVL_HI:   hit = cur;
      TRIG_RISE:     hit = edges_ok & cur & ~prev;
      TRIG_FALL:     hit = edges_ok & ~cur & prev;
      TRIG_ANY_EDGE: hit = edges_ok & (cur ^ prev);
      default:       hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pid_ctrl_regs.sv
module pid_ctrl_regs #(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 5,
  parameter int MODE_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PIN_W-1:0]           wr_idx,
  input  logic [MODE_W-1:0]          wr_mode,
  output logic [NUM_PINS*MODE_W-1:0] mode_vec
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic              load;
    logic [MODE_W-1:0] mode_d;
    logic [MODE_W-1:0] mode_q;

    always_comb begin
      load   = wr_en && (wr_idx == PIN_W'(i));
      mode_d = wr_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode_q <= '0;
      else if (load) mode_q <= mode_d;
    end

    assign mode_vec[i*MODE_W +: MODE_W] = mode_q;
  end

endmodule

// File: rtl/pid_detect.sv
module pid_detect #(
  parameter int NUM_PINS    = 32,
  parameter int MODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_q,
  input  logic [NUM_PINS*MODE_W-1:0] mode_vec,
  output logic [NUM_PINS-1:0]        set_vec
);

  localparam int WARM_LIMIT = SYNC_STAGES + 1;
  localparam int CNT_W      = $clog2(WARM_LIMIT + 1);

  logic [CNT_W-1:0]    warm_cnt_q, warm_cnt_d;
  logic                warm;
  logic [NUM_PINS-1:0] prev_q;

  // The history only holds a real sample once the synchroniser is full.
  always_comb begin
    warm       = (warm_cnt_q == CNT_W'(WARM_LIMIT));
    warm_cnt_d = warm ? warm_cnt_q : warm_cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt_q <= '0;
      prev_q     <= '0;
    end else begin
      warm_cnt_q <= warm_cnt_d;
      prev_q     <= pin_q;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_hit
    assign set_vec[i] = pid_pkg::trig_hit(mode_vec[i*MODE_W +: MODE_W],
                                          pin_q[i], prev_q[i], warm);
  end

endmodule

// File: rtl/pid_status.sv
module pid_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] flags,
  output logic                any_flag
);

  logic [NUM_PINS-1:0] flags_q, flags_d;

  // Set is ORed in after the clear, so it wins a collision.
  always_comb flags_d = (flags_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags    = flags_q;
  assign any_flag = |flags_q;

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_out
);

  localparam int MODE_W = pid_pkg::MODE_W;
  localparam int MODE_LSB = pid_pkg::MODE_LSB;
  localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(pid_pkg::STATUS_OFFSET);

  logic [ADDR_W-3:0]             word_idx;
  logic [PIN_W-1:0]              pin_idx;
  logic                          ctrl_hit;
  logic                          status_hit;
  logic [NUM_PINS-1:0]           pin_q;
  logic [NUM_PINS*MODE_W-1:0]    mode_vec;
  logic [NUM_PINS-1:0]           set_vec;
  logic [NUM_PINS-1:0]           clr_vec;
  logic [NUM_PINS-1:0]           flags_q;

  // Address decode
  always_comb begin
    word_idx   = bus_addr[ADDR_W-1:2];
    pin_idx    = word_idx[PIN_W-1:0];
    ctrl_hit   = bus_sel && (bus_addr[1:0] == 2'b00) && (int'(word_idx) < NUM_PINS);
    status_hit = bus_sel && (bus_addr == STATUS_ADDR);
    clr_vec    = (status_hit && bus_we) ? bus_wdata[NUM_PINS-1:0] : '0;
  end

  pid_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_in),
    .q     (pin_q)
  );

  pid_ctrl_regs #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .MODE_W(MODE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_hit && bus_we),
    .wr_idx   (pin_idx),
    .wr_mode  (bus_wdata[MODE_LSB +: MODE_W]),
    .mode_vec (mode_vec)
  );

  pid_detect #(.NUM_PINS(NUM_PINS), .MODE_W(MODE_W), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_q    (pin_q),
    .mode_vec (mode_vec),
    .set_vec  (set_vec)
  );

  pid_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .flags    (flags_q),
    .any_flag (irq_out)
  );

  // Same-cycle read mux
  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit && !bus_we) begin
      bus_rdata[MODE_LSB +: MODE_W] = mode_vec[pin_idx*MODE_W +: MODE_W];
    end else if (status_hit && !bus_we) begin
      bus_rdata[NUM_PINS-1:0] = flags_q;
    end
  end

endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq_out,
  input logic                   bus_sel,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic [NUM_PINS-1:0]    flags_q,
  input logic [NUM_PINS-1:0]    set_vec,
  input logic [NUM_PINS-1:0]    clr_vec,
  input logic [NUM_PINS*4-1:0]  mode_vec
);

  localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(160);

  assert_irq_matches_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == ST_ADDR) |-> (irq_out == (bus_rdata != '0)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  assert_flag_needs_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_quiet
    logic [3:0] m;
    assign m = mode_vec[i*4 +: 4];
    assert_unlisted_mode_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(m == 4'h8 || m == 4'h9 || m == 4'hA || m == 4'hB || m == 4'hC) |-> !set_vec[i]);
  end

endmodule

bind pin_irq_detect pid_checker #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_pid_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_out   (irq_out),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .flags_q   (flags_q),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .mode_vec  (mode_vec)
);

// File: tb/test_pin_irq_detect.sv
module test_pin_irq_detect;

  logic        clk;
  logic        rst_n;
  logic [31:0] pins_in;
  logic        bus_sel;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  pin_irq_detect i_pin_irq_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_in   (pins_in),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] pins_v;

  // Reference state, built from the requirements
  logic [3:0]  m_mode [32];
  logic [31:0] m_s1, m_s2, m_prev, m_flags;
  int          m_cnt;

  function automatic logic [31:0] mode_word(input logic [3:0] m);
    return {12'h000, m, 16'h0000};
  endfunction

  function automatic logic exp_hit(input logic [3:0] md, input logic c, input logic p, input bit ok);
    case (md)
      4'h8: return !c;
      4'hC: return c;
      4'h9: return ok && c && !p;
      4'hA: return ok && !c && p;
      4'hB: return ok && (c != p);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_ctrl(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a < 8'd128);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (is_ctrl(a)) return mode_word(m_mode[a[6:2]]);
    if (a == 8'hA0) return m_flags;
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_mode[i] = 4'h0;
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_flags = '0; m_cnt = 0;
  endtask

  // One bus cycle; called just after a falling edge.
  task automatic cyc(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] wd,
                     input string tag, input bit lit_en, input logic [31:0] lit);
    logic [31:0] set, clr;
    pins_in   = pins_v;
    bus_sel   = wr | rd;
    bus_we    = wr;
    bus_addr  = a;
    bus_wdata = wd;
    #1;
    if (rd) begin
      check(tag, bus_rdata, exp_read(a));
      if (lit_en) check(tag, bus_rdata, lit);
    end
    @(posedge clk);
    set = '0;
    for (int i = 0; i < 32; i++)
      set[i] = exp_hit(m_mode[i], m_s2[i], m_prev[i], m_cnt >= 3);
    clr = (wr && a == 8'hA0) ? wd : 32'h0;
    m_flags = (m_flags & ~clr) | set;
    m_prev  = m_s2;
    m_s2    = m_s1;
    m_s1    = pins_v;
    if (wr && is_ctrl(a)) m_mode[a[6:2]] = wd[19:16];
    if (m_cnt < 3) m_cnt++;
    @(negedge clk);
    check("R9 irq", {31'h0, irq_out}, {31'h0, |m_flags});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 8'h00, 32'h0, "idle", 1'b0, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, "wr", 1'b0, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    cyc(1'b0, 1'b1, a, 32'h0, tag, 1'b1, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    pins_v = 32'hFFFF_FFFF;
    pins_in = pins_v; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: rising-edge code written right after reset with pins high
    wr(8'h00, mode_word(4'h9));
    rd(8'h7C, 32'h0, "R1 ctrl31");
    rd(8'hA0, 32'h0, "R1 status");
    rd(8'h04, 32'h0, "R1 ctrl1");
    idle(3);
    rd(8'hA0, 32'h0, "R11 no spurious edge");

    // R2 field position and unmapped addresses; R3 unlisted code
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h000F_0000, "R2 field readback");
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h84, 32'h0, "R2 unmapped");
    rd(8'h02, 32'h0, "R2 misaligned");
    pins_v[2] = 1'b0; idle(4);
    pins_v[2] = 1'b1; idle(4);
    rd(8'hA0, 32'h0, "R3 unlisted code quiet");

    // R4 rising edge and stickiness; R7 write-one-to-clear
    pins_v[0] = 1'b0; idle(4);
    rd(8'hA0, 32'h0, "R4 no flag on fall");
    pins_v[0] = 1'b1; idle(3);
    rd(8'hA0, 32'h1, "R4 rise flagged");
    idle(5);
    rd(8'hA0, 32'h1, "R4 sticky");
    wr(8'hA0, 32'hFFFF_FFFE);
    rd(8'hA0, 32'h1, "R7 zero keeps");
    wr(8'hA0, 32'h1);
    rd(8'hA0, 32'h0, "R7 one clears");

    // R5 falling and either edge
    wr(8'h0C, mode_word(4'hA));
    wr(8'h10, mode_word(4'hB));
    pins_v[3] = 1'b0; pins_v[4] = 1'b0; idle(4);
    rd(8'hA0, 32'h18, "R5 fall and either");
    wr(8'hA0, 32'hFFFF_FFFF);
    pins_v[3] = 1'b1; pins_v[4] = 1'b1; idle(4);
    rd(8'hA0, 32'h10, "R5 either on rise");
    wr(8'hA0, 32'hFFFF_FFFF);

    // R6 level low; R8 clear during active level
    wr(8'h14, mode_word(4'h8));
    idle(3);
    rd(8'hA0, 32'h0, "R6 inactive level");
    pins_v[5] = 1'b0; idle(4);
    rd(8'hA0, 32'h20, "R6 level low");
    wr(8'hA0, 32'h20);
    rd(8'hA0, 32'h20, "R8 set beats clear");
    pins_v[5] = 1'b1; idle(4);
    wr(8'hA0, 32'h20);
    rd(8'hA0, 32'h0, "R6 clears once level gone");

    // R10 disable stops new flags, keeps old ones
    wr(8'h14, 32'h0);
    pins_v[5] = 1'b0; idle(4);
    rd(8'hA0, 32'h0, "R10 disabled pin quiet");
    wr(8'h18, mode_word(4'hC));
    idle(3);
    wr(8'h18, 32'h0);
    idle(3);
    rd(8'hA0, 32'h40, "R10 old flag kept");
    wr(8'hA0, 32'hFFFF_FFFF);
    idle(1);
    rd(8'hA0, 32'h0, "R7 clear all");

    // Random traffic against the reference state
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] codes [8];
      int op;
      logic [7:0] a;
      codes = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hF, 4'h3};
      if ($urandom_range(3) == 0) pins_v = pins_v ^ ($urandom() & $urandom());
      op = $urandom_range(7);
      a = {1'b0, 5'($urandom_range(31)), 2'b00};
      case (op)
        0: cyc(1'b1, 1'b0, a, ($urandom() & 32'hFFF0_FFFF) | mode_word(codes[$urandom_range(7)]),
               "R3 rnd write", 1'b0, 32'h0);
        1: cyc(1'b1, 1'b0, 8'hA0, $urandom() & $urandom(), "R7 rnd clear", 1'b0, 32'h0);
        2: cyc(1'b0, 1'b1, a, 32'h0, "R2 rnd ctrl read", 1'b0, 32'h0);
        3: cyc(1'b0, 1'b1, 8'($urandom()), 32'h0, "R2 rnd any read", 1'b0, 32'h0);
        default: cyc(1'b0, 1'b1, 8'hA0, 32'h0, "R5,R6,R8 rnd status", 1'b0, 32'h0);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule